// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block is the register front end of an I/O interrupt controller. Software sees only two 32-bit offsets. The first is an 8-bit select latch. The second is a data window, and its meaning depends on the value in the latch. Through the window, software reaches three things: a 4-bit controller identifier, a read-only version word, and a table of 64-bit routing entries, one entry per input pin. Each entry is reached as two 32-bit halves. The block holds the table itself and exports the mask, trigger and remote-IRR flags of every entry to the pin-service logic. It also takes hardware updates for the status bits that software may not write.

After each window write that lands on a table entry, a small event sequencer reports the write one cycle later. It has two states. `EV_IDLE` moves to `EV_REPORT` on any table write. `EV_REPORT` stays in `EV_REPORT` if another table write arrives, and otherwise returns to `EV_IDLE`. While in `EV_REPORT`, the sequencer pulses a mask-change notification if the mask flag of the written entry changed, giving the pin and the new mask value. It raises a service request if the entry is now level triggered and the pin's request bit was set when the write happened.

Reads return their data in a register, one cycle after the request.

Top module: `irq_route_regfile`

## Requirements
- R1: A write to offset 0x00 stores bits 7:0 of the data into the select latch, and the upper bits are dropped. A read of offset 0x00 returns the latch zero-extended.
- R2: Offsets other than 0x00 and 0x10 read as 0. Writes to them change no state.
- R3: With select 0x01, the window reads `((PINS-1) & 0xFF) << 16 | VER_CODE`. Writes there are ignored.
- R4: With select 0x00, a window write stores data bits 27:24 as the ID, and a window read returns the ID at bits 27:24 with all other bits 0. Select 0x02 reads the same value. Writes to select 0x02 are ignored.
- R5: For select values of 0x10 and above, the entry index is `(select-0x10)>>1`. Select bit 0 = 0 addresses entry bits 31:0, and bit 0 = 1 addresses bits 63:32. A window write replaces only the addressed half.
- R6: A window access whose select is 0x03 to 0x0F, or whose index is PINS or more, reads all ones. Writes there are ignored.
- R7: A window write leaves entry bit 14 (remote IRR) unchanged, except as R8 states. It never sets entry bit 12 (delivery status) from the data.
- R8: If entry bit 15 (trigger, 0 = edge, 1 = level) is 0 after a window write to that entry, bit 14 is 0 after that write.
- R9: In the cycle after a window write to an entry whose bit 16 (mask) changed, `mask_evt` is 1, `evt_pin` holds the entry index and `mask_val` holds the new mask. If the mask did not change, `mask_evt` stays 0.
- R10: In the cycle after a window write, `svc_req` is 1 exactly when the written entry has bit 15 = 1 and `pin_req` for that pin was 1 in the write cycle.
- R11: After reset, every entry is 0 except bit 16, which is 1. The select latch and the ID are 0.
- R12: A read request is answered in the next cycle with `bus_rvalid` = 1 and the data. In every other cycle, `bus_rvalid` is 0.
- R13: `rirr_set[p]` sets entry bit 14, `rirr_clr[p]` clears it, and clear wins over set. Bit 12 follows `dstat_in[p]` with one cycle delay. The outputs `ent_mask`, `ent_level` and `ent_rirr` show bits 16, 15 and 14 of each entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_valid | input | 1 | access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | register offset |
| bus_wdata | input | 32 | write data |
| bus_rvalid | output | 1 | read data valid |
| bus_rdata | output | 32 | read data |
| pin_req | input | PINS | pending request bit per pin |
| rirr_set | input | PINS | hardware sets remote IRR |
| rirr_clr | input | PINS | hardware clears remote IRR |
| dstat_in | input | PINS | delivery status per pin |
| ent_mask | output | PINS | mask flag per entry |
| ent_level | output | PINS | level-trigger flag per entry |
| ent_rirr | output | PINS | remote IRR flag per entry |
| evt_pin | output | $clog2(PINS) | pin of the reported write |
| mask_evt | output | 1 | mask changed on the reported write |
| mask_val | output | 1 | new mask value |
| svc_req | output | 1 | service request for `evt_pin` |

## Verification
The bench builds the block with PINS = 24 and VER_CODE = 0x11. With 24 entries, select values 0x10 to 0x3F hit real entries. Values from 0x40 up, and the gap 0x03 to 0x0F, fall outside the table. Both out-of-range regions can therefore be reached with the 8-bit latch. A pin count that is not a power of two also exercises the index limit check.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // entry field positions used by the neighbouring service logic
    localparam int F_DSTAT = 12;
    localparam int F_RIRR  = 14;
    localparam int F_TRIG  = 15;
    localparam int F_MASK  = 16;

    // bus offsets
    localparam logic [7:0] OFS_SEL = 8'h00;
    localparam logic [7:0] OFS_WIN = 8'h10;

    // select codes
    localparam logic [7:0] SEL_ID   = 8'h00;
    localparam logic [7:0] SEL_VER  = 8'h01;
    localparam logic [7:0] SEL_ARB  = 8'h02;
    localparam logic [7:0] SEL_TBL0 = 8'h10;

    typedef enum logic [2:0] {
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_ENTRY,
        TGT_NONE
    } tgt_e;

    typedef enum logic {
        EV_IDLE,
        EV_REPORT
    } ev_state_e;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int PINS = 24
) (
    input  logic [7:0] sel,
    output tgt_e       tgt,
    output logic [7:0] idx,
    output logic       hi_half
);

    localparam logic [7:0] PINS_B = 8'(PINS);

    logic [7:0] diff;

    always_comb begin
        diff    = sel - SEL_TBL0;
        idx     = {1'b0, diff[7:1]};
        hi_half = sel[0];
        if (sel == SEL_ID) begin
            tgt = TGT_ID;
        end else if (sel == SEL_VER) begin
            tgt = TGT_VER;
        end else if (sel == SEL_ARB) begin
            tgt = TGT_ARB;
        end else if ((sel >= SEL_TBL0) && (idx < PINS_B)) begin
            tgt = TGT_ENTRY;
        end else begin
            tgt = TGT_NONE;
        end
    end

endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        rirr_clr,
    input  logic        dstat_in,
    output logic [63:0] bits_o
);

    localparam logic [63:0] RST_VAL = 64'd1 << F_MASK;

    logic [63:0] bits_q;
    logic [63:0] bits_d;

    always_comb begin
        bits_d = bits_q;
        if (wr_en) begin
            if (wr_hi) begin
                bits_d[63:32] = wdata;
            end else begin
                bits_d[31:0] = wdata;
            end
            bits_d[F_RIRR] = bits_q[F_RIRR];
        end
        if (rirr_set) begin
            bits_d[F_RIRR] = 1'b1;
        end
        if (rirr_clr) begin
            bits_d[F_RIRR] = 1'b0;
        end
        if (wr_en && !bits_d[F_TRIG]) begin
            bits_d[F_RIRR] = 1'b0;
        end
        bits_d[F_DSTAT] = dstat_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= RST_VAL;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign bits_o = bits_q;

    a_r8_edge_write_clears_rirr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bits_q[F_TRIG] || !bits_q[F_RIRR]));

    a_r7_rirr_kept_on_high_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi && bits_q[F_TRIG] && !rirr_set && !rirr_clr)
        |=> (bits_q[F_RIRR] == $past(bits_q[F_RIRR])));

    a_r13_dstat_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bits_q[F_DSTAT] == $past(dstat_in)));

    a_r5_low_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> (bits_q[31:17] == $past(bits_q[31:17])
                              && bits_q[11:0] == $past(bits_q[11:0])));

endmodule

// File: rtl/irq_route_evctl.sv
module irq_route_evctl
    import irq_route_pkg::*;
#(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tbl_wr,
    input  logic [PW-1:0] wr_pin,
    input  logic          old_mask,
    input  logic          req_now,
    input  logic          cur_mask,
    input  logic          cur_level,
    output logic [PW-1:0] evt_pin,
    output logic          mask_evt,
    output logic          mask_val,
    output logic          svc_req
);

    ev_state_e     state_q;
    ev_state_e     state_d;
    logic [PW-1:0] pin_q;
    logic          old_mask_q;
    logic          req_q;

    // state register and capture of the reported write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= EV_IDLE;
            pin_q      <= '0;
            old_mask_q <= 1'b0;
            req_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (tbl_wr) begin
                pin_q      <= wr_pin;
                old_mask_q <= old_mask;
                req_q      <= req_now;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            EV_IDLE:   state_d = tbl_wr ? EV_REPORT : EV_IDLE;
            EV_REPORT: state_d = tbl_wr ? EV_REPORT : EV_IDLE;
            default:   state_d = EV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        evt_pin  = pin_q;
        mask_evt = 1'b0;
        mask_val = 1'b0;
        svc_req  = 1'b0;
        unique case (state_q)
            EV_IDLE: begin
            end
            EV_REPORT: begin
                mask_evt = (cur_mask != old_mask_q);
                mask_val = cur_mask;
                svc_req  = cur_level && req_q;
            end
            default: begin
            end
        endcase
    end

    a_r9_report_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_evt || svc_req) |-> $past(tbl_wr));

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irq_route_pkg::*;
#(
    parameter int         PINS     = 24,
    parameter logic [7:0] VER_CODE = 8'h11,
    localparam int        PW       = $clog2(PINS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_valid,
    input  logic            bus_write,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic            bus_rvalid,
    output logic [31:0]     bus_rdata,
    input  logic [PINS-1:0] pin_req,
    input  logic [PINS-1:0] rirr_set,
    input  logic [PINS-1:0] rirr_clr,
    input  logic [PINS-1:0] dstat_in,
    output logic [PINS-1:0] ent_mask,
    output logic [PINS-1:0] ent_level,
    output logic [PINS-1:0] ent_rirr,
    output logic [PW-1:0]   evt_pin,
    output logic            mask_evt,
    output logic            mask_val,
    output logic            svc_req
);

    localparam logic [31:0] VER_WORD = {8'h00, 8'(PINS - 1), 8'h00, VER_CODE};

    logic [7:0]  sel_q;
    logic [3:0]  id_q;
    tgt_e        tgt;
    logic [7:0]  idx;
    logic        hi_half;
    logic [PW-1:0] idx_w;
    logic        sel_wr;
    logic        win_wr;
    logic        tbl_wr;
    logic        rd_req;
    logic [31:0] rd_val;
    logic [31:0] win_val;
    logic [63:0] tbl [PINS];

    irq_route_decode #(.PINS(PINS)) dec_i (
        .sel     (sel_q),
        .tgt     (tgt),
        .idx     (idx),
        .hi_half (hi_half)
    );

    assign idx_w  = idx[PW-1:0];
    assign sel_wr = bus_valid && bus_write && (bus_addr == OFS_SEL);
    assign win_wr = bus_valid && bus_write && (bus_addr == OFS_WIN);
    assign tbl_wr = win_wr && (tgt == TGT_ENTRY);
    assign rd_req = bus_valid && !bus_write;

    genvar p;
    generate
        for (p = 0; p < PINS; p++) begin : g_ent
            irq_route_entry ent_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (tbl_wr && (idx == 8'(p))),
                .wr_hi    (hi_half),
                .wdata    (bus_wdata),
                .rirr_set (rirr_set[p]),
                .rirr_clr (rirr_clr[p]),
                .dstat_in (dstat_in[p]),
                .bits_o   (tbl[p])
            );
            assign ent_mask[p]  = tbl[p][F_MASK];
            assign ent_level[p] = tbl[p][F_TRIG];
            assign ent_rirr[p]  = tbl[p][F_RIRR];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (sel_wr) begin
                sel_q <= bus_wdata[7:0];
            end
            if (win_wr && (tgt == TGT_ID)) begin
                id_q <= bus_wdata[27:24];
            end
        end
    end

    always_comb begin
        unique case (tgt)
            TGT_ID:    win_val = {4'h0, id_q, 24'h0};
            TGT_ARB:   win_val = {4'h0, id_q, 24'h0};
            TGT_VER:   win_val = VER_WORD;
            TGT_ENTRY: win_val = hi_half ? tbl[idx_w][63:32] : tbl[idx_w][31:0];
            default:   win_val = '1;
        endcase
        if (bus_addr == OFS_SEL) begin
            rd_val = {24'h0, sel_q};
        end else if (bus_addr == OFS_WIN) begin
            rd_val = win_val;
        end else begin
            rd_val = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_req;
            if (rd_req) begin
                bus_rdata <= rd_val;
            end
        end
    end

    irq_route_evctl #(.PW(PW)) ev_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl_wr    (tbl_wr),
        .wr_pin    (idx_w),
        .old_mask  (ent_mask[idx_w]),
        .req_now   (pin_req[idx_w]),
        .cur_mask  (ent_mask[evt_pin]),
        .cur_level (ent_level[evt_pin]),
        .evt_pin   (evt_pin),
        .mask_evt  (mask_evt),
        .mask_val  (mask_val),
        .svc_req   (svc_req)
    );

    a_r1_sel_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (sel_q == $past(bus_wdata[7:0])));

    a_r12_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    a_r12_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);

    a_r10_svc_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> ent_level[evt_pin]);

    a_r4_id_only_by_id_select: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_wr && (tgt == TGT_ID)) |=> (id_q == $past(id_q)));

    a_r2_other_offset_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr != OFS_SEL && bus_addr != OFS_WIN)
        |=> (sel_q == $past(sel_q) && id_q == $past(id_q)));

endmodule

// File: tb/irq_route_regfile_tb_top.sv
module irq_route_regfile_tb_top;

    localparam int         PINS = 24;
    localparam int         PW   = $clog2(PINS);
    localparam logic [7:0] VER  = 8'h11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_rvalid;
    logic [31:0]     bus_rdata;
    logic [PINS-1:0] pin_req = '0;
    logic [PINS-1:0] rirr_set = '0;
    logic [PINS-1:0] rirr_clr = '0;
    logic [PINS-1:0] dstat_in = '0;
    logic [PINS-1:0] ent_mask;
    logic [PINS-1:0] ent_level;
    logic [PINS-1:0] ent_rirr;
    logic [PW-1:0]   evt_pin;
    logic            mask_evt;
    logic            mask_val;
    logic            svc_req;

    int total = 0;
    int bad   = 0;

    logic [7:0]  m_sel = '0;
    logic [3:0]  m_id = '0;
    logic [63:0] m_tbl [PINS];

    always #5 clk = ~clk;

    irq_route_regfile #(.PINS(PINS), .VER_CODE(VER)) dut_i (
        .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
        .bus_rvalid, .bus_rdata, .pin_req, .rirr_set, .rirr_clr, .dstat_in,
        .ent_mask, .ent_level, .ent_rirr, .evt_pin, .mask_evt, .mask_val, .svc_req
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected window/offset read value from the model (R1..R6)
    function automatic logic [31:0] m_read(input logic [7:0] a, output string tag);
        int i;
        tag = "R2";
        if (a == 8'h00) begin
            tag = "R1";
            return {24'h0, m_sel};
        end
        if (a != 8'h10) return 32'h0;
        if (m_sel == 8'h00 || m_sel == 8'h02) begin
            tag = "R4";
            return {4'h0, m_id, 24'h0};
        end
        if (m_sel == 8'h01) begin
            tag = "R3";
            return {8'h00, 8'(PINS - 1), 8'h00, VER};
        end
        tag = "R6";
        if (m_sel < 8'h10) return 32'hFFFF_FFFF;
        i = int'(m_sel - 8'h10) >> 1;
        if (i >= PINS) return 32'hFFFF_FFFF;
        tag = "R5";
        return m_sel[0] ? m_tbl[i][63:32] : m_tbl[i][31:0];
    endfunction

    function automatic int m_pin();
        int i;
        if (m_sel < 8'h10) return -1;
        i = int'(m_sel - 8'h10) >> 1;
        return (i < PINS) ? i : -1;
    endfunction

    // one bus cycle; called at a falling edge, returns at the next falling edge
    task automatic step(input logic v, input logic w, input logic [7:0] a,
                        input logic [31:0] d);
        logic [31:0] exp_rd;
        string       rtag;
        int          pin;
        logic        old_m;
        logic        exp_evt;
        logic        exp_svc;
        logic [63:0] e;
        bus_valid = v;
        bus_write = w;
        bus_addr  = a;
        bus_wdata = d;
        exp_rd = m_read(a, rtag);
        pin = (v && w && a == 8'h10) ? m_pin() : -1;
        old_m = (pin >= 0) ? m_tbl[pin][16] : 1'b0;
        // model update for this edge
        for (int p = 0; p < PINS; p++) begin
            e = m_tbl[p];
            if (p == pin) begin
                if (m_sel[0]) e[63:32] = d;
                else e[31:0] = d;
                e[14] = m_tbl[p][14];
            end
            if (rirr_set[p]) e[14] = 1'b1;
            if (rirr_clr[p]) e[14] = 1'b0;
            if (p == pin && !e[15]) e[14] = 1'b0;
            e[12] = dstat_in[p];
            m_tbl[p] = e;
        end
        exp_evt = (pin >= 0) && (m_tbl[pin][16] != old_m);
        exp_svc = (pin >= 0) && m_tbl[pin][15] && pin_req[pin];
        if (v && w && a == 8'h10 && m_sel == 8'h00) m_id = d[27:24];
        if (v && w && a == 8'h00) m_sel = d[7:0];
        @(negedge clk);
        bus_valid = 1'b0;
        chk(bus_rvalid == (v && !w), "R12", 64'(bus_rvalid), 64'(v && !w));
        if (v && !w) chk(bus_rdata == exp_rd, rtag, 64'(bus_rdata), 64'(exp_rd));
        chk(mask_evt == exp_evt, "R9", 64'(mask_evt), 64'(exp_evt));
        if (exp_evt) begin
            chk(evt_pin == PW'(pin), "R9", 64'(evt_pin), 64'(pin));
            chk(mask_val == m_tbl[pin][16], "R9", 64'(mask_val), 64'(m_tbl[pin][16]));
        end
        chk(svc_req == exp_svc, "R10", 64'(svc_req), 64'(exp_svc));
        for (int p = 0; p < PINS; p++) begin
            chk(ent_mask[p] == m_tbl[p][16], "R13", 64'(ent_mask[p]), 64'(m_tbl[p][16]));
            chk(ent_level[p] == m_tbl[p][15], "R13", 64'(ent_level[p]), 64'(m_tbl[p][15]));
            chk(ent_rirr[p] == m_tbl[p][14], "R8", 64'(ent_rirr[p]), 64'(m_tbl[p][14]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int p = 0; p < PINS; p++) m_tbl[p] = 64'd1 << 16;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(ent_mask == '1, "R11", 64'(ent_mask), 64'(PINS'('1)));
        chk(ent_rirr == '0, "R11", 64'(ent_rirr), 64'h0);
        chk(!bus_rvalid && !mask_evt && !svc_req, "R11", 64'(bus_rvalid), 64'h0);
        step(1, 0, 8'h00, 0);                  // R11 select reads 0
        step(1, 0, 8'h10, 0);                  // R11 ID reads 0
        // R1: upper bits dropped
        step(1, 1, 8'h00, 32'h0000_01AB);
        step(1, 0, 8'h00, 0);
        // R2: other offset inert
        step(1, 1, 8'h04, 32'h1234_5678);
        step(1, 0, 8'h04, 0);
        step(1, 0, 8'h00, 0);
        // R3: version word, write ignored
        step(1, 1, 8'h00, 32'h01);
        step(1, 0, 8'h10, 0);
        step(1, 1, 8'h10, 32'hFFFF_FFFF);
        step(1, 0, 8'h10, 0);
        // R4: ID write, arbitration alias, alias write ignored
        step(1, 1, 8'h00, 32'h00);
        step(1, 1, 8'h10, 32'hF5FF_FFFF);
        step(1, 0, 8'h10, 0);
        step(1, 1, 8'h00, 32'h02);
        step(1, 0, 8'h10, 0);
        step(1, 1, 8'h10, 32'h0A00_0000);
        step(1, 0, 8'h10, 0);
        // R6: gap below table and beyond last entry
        step(1, 1, 8'h00, 32'h05);
        step(1, 0, 8'h10, 0);
        step(1, 1, 8'h00, 32'(8'h10 + 2 * PINS));
        step(1, 1, 8'h10, 32'h0);
        step(1, 0, 8'h10, 0);
        // R9/R10: entry 3 unmasked, level, request pending
        pin_req = PINS'(1) << 3;
        step(1, 1, 8'h00, 32'h16);
        step(1, 1, 8'h10, 32'h0000_80A5);
        // R13: hardware sets remote IRR on entry 3
        rirr_set = PINS'(1) << 3;
        step(0, 0, 8'h00, 0);
        rirr_set = '0;
        // R7: level rewrite and high-half write keep remote IRR
        step(1, 1, 8'h10, 32'h0000_C0A5);
        chk(ent_rirr[3] == 1'b1, "R7", 64'(ent_rirr[3]), 64'h1);
        step(1, 1, 8'h00, 32'h17);
        step(1, 1, 8'h10, 32'hAB00_0000);
        chk(ent_rirr[3] == 1'b1, "R7", 64'(ent_rirr[3]), 64'h1);
        step(1, 0, 8'h10, 0);
        // R8: edge trigger write clears remote IRR; mask set again (R9)
        step(1, 1, 8'h00, 32'h16);
        step(1, 1, 8'h10, 32'h0001_40A5);
        chk(ent_rirr[3] == 1'b0, "R8", 64'(ent_rirr[3]), 64'h0);
        step(1, 0, 8'h10, 0);
        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int          k;
            pin_req  = PINS'($urandom);
            rirr_set = PINS'($urandom & $urandom & $urandom);
            rirr_clr = PINS'($urandom & $urandom & $urandom);
            dstat_in = PINS'($urandom);
            k = int'($urandom_range(0, 9));
            d = $urandom;
            if (k < 3) begin
                a = 8'h00;
                if ($urandom_range(0, 3) != 0) d = 32'($urandom_range(0, 2 * PINS + 20));
            end else if (k < 9) begin
                a = 8'h10;
            end else begin
                a = 8'($urandom);
            end
            step($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, a, d);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule